// File: doc/BRIEF.md
# Replayable 9-bit FIFO with half-full flag

This block is a single-clock first-in/first-out buffer for 9-bit words, with a depth of 256, 512 or 1024 set by a parameter. Writes and reads are requested with active-low strobes. Internal ring pointers select the storage location, so no addresses are presented. Empty, full and half-full flags tell the producer and the consumer when to stop. Each accepted read loads the output register and raises a data-valid strobe for one cycle.

An active-low replay input rewinds the read side to storage location zero and leaves the write side where it is. Everything written since reset can then be delivered again from the first word. The flags are recomputed from the new pointer distance.

A strobe that is held low across a flag boundary acts as a pending request. A read held low while empty completes on the edge after the first write. A write held low while full completes on the edge after a read frees a slot.

Top module: `rfifo_replay`

## Requirements
- R1: Words are 9 bits wide and leave in the order they were written. DEPTH is a power of two: 256, 512 or 1024.
- R2: While the internal reset is active: `empty`=1, `full`=0, `half`=0, `dvalid`=0 and `dout`=0, and both pointers are at location zero. The internal reset follows `rst_n` low at once and is released on the second rising clock edge after `rst_n` goes high.
- R3: `empty` is 1 exactly when the occupancy is 0, and `full` is 1 exactly when the occupancy is DEPTH. The two are never 1 together. With no reads since reset, `full` rises after exactly DEPTH accepted writes.
- R4: A write request while `full`=1 is ignored and does not change the stored data or the write position.
- R5: A read request while `empty`=1 is ignored: `dvalid` stays 0, `dout` is unchanged and the read position does not move.
- R6: `half` is 1 exactly when the occupancy is greater than DEPTH/2. It rises on the write that makes the occupancy DEPTH/2+1 and falls on the read that brings it back to DEPTH/2.
- R7: When `rtx_n` is low at a rising edge, the read position returns to location zero and the occupancy becomes the write position (writes since reset, modulo DEPTH). The write position is unchanged, and any read or write request in that cycle is dropped. The following reads replay the words from the first one written.
- R8: A read and a write in the same cycle, with neither blocked, both take effect and leave the occupancy and all flags unchanged.
- R9: `dvalid` is 1 in the cycle after each accepted read and 0 otherwise. `dout` changes only when `dvalid` is 1.
- R10: A read request held low while `empty`=1 is accepted on the edge after the first write, and it returns that word.
- R11: A write request held low while `full`=1 is accepted on the edge after a read frees a slot, and `full` returns to 1.
- R12: Requests that arrive while the internal reset is active are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all requests are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write request |
| rd_n | input | 1 | Active-low read request |
| rtx_n | input | 1 | Active-low replay (rewind read side to location zero) |
| din | input | 9 | Write data |
| dout | output | 9 | Read data, held between accepted reads |
| dvalid | output | 1 | One-cycle strobe per accepted read |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy is DEPTH |
| half | output | 1 | Occupancy is above DEPTH/2 |

## Verification
A read and a write can land on the same edge. Away from the boundaries both must take effect. At the empty boundary only the write may proceed, and at the full boundary only the read may proceed. The bench provokes this by holding both strobes low in the middle of the range, and by holding one strobe low across the cycle in which the other side crosses the boundary. A behavioural reference queue, stepped on every edge, judges the result through `dout`, `dvalid` and the three flags on every cycle.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rfifo_rst_sync.sv
module rfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;
endmodule

// File: rtl/rfifo_ctrl.sv
module rfifo_ctrl #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic              rewind,
  output logic              wr_en,
  output logic              rd_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              empty,
  output logic              full,
  output logic              half
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);

  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // flags straight from the registered occupancy
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_FULL);
  assign half  = (cnt_q > CNT_HALF);

  // a request is only granted if its own boundary allows it
  assign wr_en = wr_req & ~full & ~rewind;
  assign rd_en = rd_req & ~empty & ~rewind;

  always_comb begin
    wr_addr_d = wr_addr_q;
    rd_addr_d = rd_addr_q;
    cnt_d     = cnt_q;
    if (rewind) begin
      rd_addr_d = '0;
      cnt_d     = {1'b0, wr_addr_q};
    end else begin
      if (wr_en) wr_addr_d = wr_addr_q + 1'b1;
      if (rd_en) rd_addr_d = rd_addr_q + 1'b1;
      cnt_d = cnt_q + CNT_W'(wr_en) - CNT_W'(rd_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      rd_addr_q <= '0;
      cnt_q     <= '0;
    end else begin
      wr_addr_q <= wr_addr_d;
      rd_addr_q <= rd_addr_d;
      cnt_q     <= cnt_d;
    end
  end

  assign wr_addr = wr_addr_q;
  assign rd_addr = rd_addr_q;
endmodule

// File: rtl/rfifo_store.sv
module rfifo_store
  import rfifo_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output word_t             rd_data,
  output logic              rd_valid
);
  word_t mem [DEPTH];
  word_t rd_data_q, rd_data_d;
  logic  rd_valid_q, rd_valid_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    rd_valid_d = rd_en;
    rd_data_d  = rd_data_q;
    if (rd_en) rd_data_d = mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_valid_d;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/rfifo_replay.sv
module rfifo_replay
  import rfifo_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rtx_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dvalid,
  output logic              empty,
  output logic              full,
  output logic              half
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic              core_rst_n;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  rfifo_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  rfifo_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_req  (~wr_n),
    .rd_req  (~rd_n),
    .rewind  (~rtx_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .empty   (empty),
    .full    (full),
    .half    (half)
  );

  rfifo_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (din),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (dout),
    .rd_valid (dvalid)
  );
endmodule

// File: rtl/rfifo_chk.sv
module rfifo_chk #(
  parameter int DEPTH = 1024
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_n,
  input logic       rd_n,
  input logic       rtx_n,
  input logic [8:0] dout,
  input logic       dvalid,
  input logic       empty,
  input logic       full,
  input logic       half
);
  // R3: the two boundary flags exclude each other
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R6: above half the depth can never be empty
  a_r6_half_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> !empty);

  // R4: a write alone while full leaves the buffer full
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_n && rd_n && rtx_n) |=> full);

  // R5: a read while empty produces no data strobe
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rd_n && rtx_n) |=> !dvalid);

  // R7: requests in a replay cycle are dropped
  a_r7_replay_drops_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rtx_n |=> !dvalid);

  // R8: read and write together in the middle range keep all flags
  a_r8_balanced_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !full && !rd_n && !wr_n && rtx_n) |=> $stable({empty, full, half}));

  // R9: output data moves only together with the strobe
  a_r9_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dvalid |-> $stable(dout));

  // R10: a write into an empty buffer clears empty on the next cycle
  a_r10_fill_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_n && rtx_n) |=> !empty);
endmodule

bind rfifo_replay rfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk    (clk),
  .rst_n  (core_rst_n),
  .wr_n   (wr_n),
  .rd_n   (rd_n),
  .rtx_n  (rtx_n),
  .dout   (dout),
  .dvalid (dvalid),
  .empty  (empty),
  .full   (full),
  .half   (half)
);

// File: tb/sim_rfifo_replay.sv
`timescale 1ns/1ps
module sim_rfifo_replay;
  localparam int D = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1, rd_n = 1'b1, rtx_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       dvalid, empty, full, half;

  int total = 0;
  int bad = 0;
  string tag = "R2";
  bit done = 1'b0;

  rfifo_replay #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
    .din(din), .dout(dout), .dvalid(dvalid), .empty(empty), .full(full), .half(half)
  );

  always #10 clk = ~clk;

  // behavioural reference
  logic [8:0] mm [D];
  int wpos = 0, rpos = 0, cnt = 0;
  int s1 = 0, s2 = 0;
  logic [8:0] e_dout = '0;
  logic       e_dv = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; wpos = 0; rpos = 0; cnt = 0; e_dout = '0; e_dv = 1'b0;
    end else begin
      if (s2 == 1) begin
        if (!rtx_n) begin
          rpos = 0; cnt = wpos; e_dv = 1'b0;
        end else begin
          bit rd_ok, wr_ok;
          rd_ok = !rd_n && cnt > 0;
          wr_ok = !wr_n && cnt < D;
          e_dv = rd_ok;
          if (rd_ok) begin e_dout = mm[rpos]; rpos = (rpos + 1) % D; end
          if (wr_ok) begin mm[wpos] = din; wpos = (wpos + 1) % D; end
          cnt = cnt + int'(wr_ok) - int'(rd_ok);
        end
      end
      s2 = s1; s1 = 1;
    end
  end

  task automatic check(string t, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check({tag, " dout"},   dout,   e_dout);
      check({tag, " dvalid"}, dvalid, e_dv);
      check({tag, " empty"},  empty,  cnt == 0);
      check({tag, " full"},   full,   cnt == D);
      check({tag, " half"},   half,   cnt > D/2);
    end
  end

  function automatic logic [8:0] wd(int i);
    return 9'((i * 37 + 5) & 9'h1ff);
  endfunction

  // apply inputs, let one rising edge pass, return after the next falling edge
  task automatic cyc(bit w, bit r, bit t, logic [8:0] d);
    wr_n = w; rd_n = r; rtx_n = t; din = d;
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(0, 0, 1, 9'h155);               // R12: requests while in reset
    cyc(0, 0, 1, 9'h0aa);
    check("R2 empty in reset", empty, 1);
    check("R2 dvalid in reset", dvalid, 0);
    rst_n = 1'b1;
    cyc(0, 1, 1, 9'h033);               // dropped: internal reset still held
    cyc(1, 1, 1, 0);
    cyc(1, 1, 1, 0);
    check("R12 nothing stored during reset", empty, 1);
  endtask

  initial begin
    @(negedge clk); #1;
    tag = "R2";
    do_reset();
    check("R2 full after reset", full, 0);
    check("R2 half after reset", half, 0);
    check("R2 dout after reset", dout, 0);

    tag = "R5";
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0);
    check("R5 read on empty gives no strobe", dvalid, 0);
    check("R5 dout unchanged", dout, 0);

    tag = "R1";
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, wd(i));
    cyc(1, 0, 1, 0);
    check("R1 first word out", dout, wd(0));
    check("R9 strobe on read", dvalid, 1);
    cyc(1, 1, 1, 0);
    check("R9 strobe one cycle", dvalid, 0);
    check("R9 dout held", dout, wd(0));
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0);
    check("R1 order", dout, wd(2));

    tag = "R10";
    cyc(0, 0, 1, 9'h1a5);               // empty: read pending, write lands
    check("R10 no data yet", dvalid, 0);
    cyc(1, 0, 1, 0);
    check("R10 flow-through strobe", dvalid, 1);
    check("R10 flow-through word", dout, 9'h1a5);
    cyc(1, 1, 1, 0);

    tag = "R3";
    do_reset();
    for (int i = 0; i < D; i++) begin
      cyc(0, 1, 1, wd(i + 10));
      if (i == D/2 - 1) check("R6 half at DEPTH/2", half, 0);
      if (i == D/2)     check("R6 half above DEPTH/2", half, 1);
      if (i == D - 2)   check("R3 not full one short", full, 0);
    end
    check("R3 full after DEPTH writes", full, 1);

    tag = "R4";
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 9'h1ff);
    check("R4 still full", full, 1);

    tag = "R11";
    cyc(0, 0, 1, 9'h0f0);               // read frees a slot, write blocked
    check("R11 full drops", full, 0);
    check("R4 oldest word survived", dout, wd(10));
    cyc(0, 1, 1, 9'h0f0);
    check("R11 pending write lands", full, 1);

    tag = "R6";
    for (int i = 0; i < D/2 - 1; i++) cyc(1, 0, 1, 0);
    check("R6 half held at DEPTH/2+1", half, 1);
    cyc(1, 0, 1, 0);
    check("R6 half falls at DEPTH/2", half, 0);

    tag = "R8";
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, wd(i + 500));
    check("R8 half unchanged", half, 0);
    check("R8 empty unchanged", empty, 0);
    for (int i = 0; i < D/2 + 2; i++) cyc(1, 0, 1, 0);
    check("R8 drains to empty", empty, 1);

    tag = "R7";
    do_reset();
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, wd(i + 700));
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0);
    check("R7 pre-replay read", dout, wd(701));
    cyc(0, 0, 0, 9'h111);               // replay, requests dropped
    check("R7 no strobe during replay", dvalid, 0);
    check("R7 not empty after replay", empty, 0);
    cyc(1, 0, 1, 0);
    check("R7 replays first word", dout, wd(700));
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0);
    check("R7 replays last word", dout, wd(704));
    check("R7 empty after replay", empty, 1);
    cyc(1, 1, 1, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule